// File: doc/BRIEF.md
# Bit-Serial SIMD Compute Memory Array

This block is a small storage array with two ways in. Through the row port it behaves like an ordinary memory: a full row word is written or read in one access. Through the instruction port it acts as a bit-serial vector engine. Each element of a vector occupies one row, and the bits of that element are spread across columns. A single 32-bit micro-instruction names two source columns and one destination column. Every row then applies the same one-bit operation to its own pair of bits and writes the result into its own cell of the destination column, all in the same clock cycle.

Each row has a private compute slice that holds two state bits. The carry bit chains multi-bit additions from one instruction to the next. The tag bit can gate write-back, which makes predicated execution possible. Multi-cycle operations such as multiplication or search are built outside the block as sequences of these micro-instructions.

The array is a shared resource. In any cycle it serves either a compute instruction or a row access, never both. A row access that loses one cycle to an instruction wins the following cycle.

Top module: `cim_array_top`

## Requirements
- R1: Instruction layout: bits [27:24] opcode, [23:16] column A, [15:8] column B, [7:0] column D, bit 28 the conditional-execution flag. Only the low log2(COLS) bits of each column field are used. Bits [31:29] are reserved and have no effect.
- R2: Opcodes 0 AND, 1 OR, 2 XOR, 13 NOR, 4 COPY (D=A) and 5 INV (D=~A) write their bitwise result into column D of every row.
- R3: Opcode 3 ADD writes A^B^carry into column D and updates the row's carry to the majority of A, B and the old carry at the end of the cycle.
- R4: Opcode 6 loads carry from column A, 7 stores carry to column D, 11 sets carry to 1 and 12 clears it to 0.
- R5: Opcode 8 loads tag from column A, 9 stores tag to column D, 14 sets tag to 1, and 10 sets tag to (A == instruction bit 8).
- R6: With bit 28 set, rows whose tag is 0 keep column D unchanged. Carry and tag updates still occur in those rows.
- R7: Column D may equal column A. The result then replaces the operand bit in place.
- R8: A row write stores the whole word. A row read returns the word on rowRdata with rowRvalid high one cycle after acceptance. Row accesses leave carry and tag unchanged.
- R9: An instruction is accepted when instValid is high and instBusy is low. In that cycle rowReady is low, so no row access is accepted alongside it.
- R10: A row request refused in one cycle raises instBusy and is accepted in the next cycle if still requested. The pending instruction is held off until then.
- R11: Reset clears the array, the carry and tag bits, and rowRvalid. Opcode 15 (NOP) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowReq | input | 1 | Row access request |
| rowWe | input | 1 | 1 = write, 0 = read |
| rowAddr | input | $clog2(ROWS) | Row address |
| rowWdata | input | COLS | Row write word |
| rowReady | output | 1 | Row request accepted this cycle |
| rowRdata | output | COLS | Registered read word |
| rowRvalid | output | 1 | rowRdata valid |
| instValid | input | 1 | Micro-instruction present |
| instWord | input | 32 | Micro-instruction |
| instBusy | output | 1 | Instruction not accepted this cycle |

## Verification
A fault in the column decode, or in a row slice's carry or tag, stays hidden inside the array until that column is read back through the row port. The bench therefore reads every row after each instruction and compares each row with a reference model. A fault in any single cell, or in a chained carry, then appears at most one instruction plus one read after it arises. Arbitration faults appear at once on rowReady and instBusy, or one cycle later as a lost or duplicated operation in the array contents.

// File: rtl/cim_pkg.sv
package cim_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_OR = 4'd1, OP_XOR = 4'd2, OP_ADD = 4'd3,
    OP_COPY = 4'd4, OP_INV = 4'd5, OP_LDC = 4'd6, OP_STC = 4'd7,
    OP_LDT = 4'd8, OP_STT = 4'd9, OP_EQ = 4'd10, OP_SETC = 4'd11,
    OP_CLRC = 4'd12, OP_NOR = 4'd13, OP_SETT = 4'd14, OP_NOP = 4'd15
  } opcode_e;

  typedef struct packed {
    logic       doCompute;
    opcode_e    op;
    logic       cond;
    logic       pattern;
    logic [7:0] colA;
    logic [7:0] colB;
    logic [7:0] colD;
    logic       rowWr;
    logic       rowRd;
  } strobe_t;
endpackage

// File: rtl/cim_ctrl.sv
module cim_ctrl
  import cim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rowReq,
  input  logic        rowWe,
  input  logic        instValid,
  input  logic [31:0] instWord,
  output logic        rowReady,
  output logic        instBusy,
  output strobe_t     st
);
  logic stallQ;
  logic instFire;
  logic rowFire;
  logic unusedRsvd;

  assign unusedRsvd = ^instWord[31:29];
  assign instBusy   = stallQ & rowReq;
  assign instFire   = instValid & ~instBusy;
  assign rowReady   = ~instFire;
  assign rowFire    = rowReq & rowReady;

  always_ff @(posedge clk) begin
    if (!rstN) stallQ <= 1'b0;
    else       stallQ <= rowReq & ~rowReady;
  end

  always_comb begin
    st.doCompute = instFire;
    st.op        = opcode_e'(instWord[27:24]);
    st.cond      = instWord[28];
    st.pattern   = instWord[8];
    st.colA      = instWord[23:16];
    st.colB      = instWord[15:8];
    st.colD      = instWord[7:0];
    st.rowWr     = rowFire & rowWe;
    st.rowRd     = rowFire & ~rowWe;
  end

  p_no_starve_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rowReq && !rowReady) |=> (!rowReq || rowReady));
  p_busy_frees_row_r9: assert property (@(posedge clk) disable iff (!rstN)
    instBusy |-> rowReady);
endmodule

// File: rtl/cim_row_slice.sv
module cim_row_slice
  import cim_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t st,
  input  logic    aBit,
  input  logic    bBit,
  output logic    wrBit,
  output logic    wrEn
);
  logic carryQ, tagQ;
  logic writes;
  logic unusedSt;

  assign unusedSt = ^{st.colA, st.colB, st.colD, st.rowWr, st.rowRd};

  always_comb begin
    wrBit  = 1'b0;
    writes = 1'b1;
    case (st.op)
      OP_AND:  wrBit = aBit & bBit;
      OP_OR:   wrBit = aBit | bBit;
      OP_XOR:  wrBit = aBit ^ bBit;
      OP_NOR:  wrBit = ~(aBit | bBit);
      OP_ADD:  wrBit = aBit ^ bBit ^ carryQ;
      OP_COPY: wrBit = aBit;
      OP_INV:  wrBit = ~aBit;
      OP_STC:  wrBit = carryQ;
      OP_STT:  wrBit = tagQ;
      default: writes = 1'b0;
    endcase
  end

  assign wrEn = st.doCompute & writes & (~st.cond | tagQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      tagQ   <= 1'b0;
    end else if (st.doCompute) begin
      case (st.op)
        OP_ADD:  carryQ <= (aBit & bBit) | (aBit & carryQ) | (bBit & carryQ);
        OP_LDC:  carryQ <= aBit;
        OP_SETC: carryQ <= 1'b1;
        OP_CLRC: carryQ <= 1'b0;
        OP_LDT:  tagQ   <= aBit;
        OP_EQ:   tagQ   <= (aBit == st.pattern);
        OP_SETT: tagQ   <= 1'b1;
        default: ;
      endcase
    end
  end

  p_setc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.doCompute && st.op == OP_SETC) |=> carryQ);
  p_clrc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.doCompute && st.op == OP_CLRC) |=> !carryQ);
  p_sett_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.doCompute && st.op == OP_SETT) |=> tagQ);
  p_idle_keeps_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!st.doCompute || st.op == OP_NOP) |=> ($stable(carryQ) && $stable(tagQ)));
endmodule

// File: rtl/cim_datapath.sv
module cim_datapath
  import cim_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 32,
  localparam int RAW = $clog2(ROWS),
  localparam int CAW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic [RAW-1:0]  rowAddr,
  input  logic [COLS-1:0] rowWdata,
  output logic [COLS-1:0] rowRdata,
  output logic            rowRvalid
);
  logic [ROWS-1:0][COLS-1:0] memQ;
  logic [ROWS-1:0] wrBit, wrEn;
  logic [CAW-1:0] colA, colB, colD;

  assign colA = st.colA[CAW-1:0];
  assign colB = st.colB[CAW-1:0];
  assign colD = st.colD[CAW-1:0];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    cim_row_slice u_slice (
      .clk(clk), .rstN(rstN), .st(st),
      .aBit(memQ[g][colA]), .bBit(memQ[g][colB]),
      .wrBit(wrBit[g]), .wrEn(wrEn[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memQ      <= '0;
      rowRdata  <= '0;
      rowRvalid <= 1'b0;
    end else begin
      rowRvalid <= st.rowRd;
      if (st.rowRd) rowRdata <= memQ[rowAddr];
      if (st.rowWr) memQ[rowAddr] <= rowWdata;
      for (int r = 0; r < ROWS; r++) begin
        if (wrEn[r]) memQ[r][colD] <= wrBit[r];
      end
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(st.doCompute && (st.rowWr || st.rowRd)));
  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.rowRd |=> rowRvalid);
  p_rowwr_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.rowWr |=> (memQ[$past(rowAddr)] == $past(rowWdata)));
endmodule

// File: rtl/cim_array_top.sv
module cim_array_top
  import cim_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 32,
  localparam int RAW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rowReq,
  input  logic            rowWe,
  input  logic [RAW-1:0]  rowAddr,
  input  logic [COLS-1:0] rowWdata,
  output logic            rowReady,
  output logic [COLS-1:0] rowRdata,
  output logic            rowRvalid,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  output logic            instBusy
);
  strobe_t st;

  cim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rowReq(rowReq), .rowWe(rowWe),
    .instValid(instValid), .instWord(instWord),
    .rowReady(rowReady), .instBusy(instBusy), .st(st)
  );

  cim_datapath #(.ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .rowAddr(rowAddr),
    .rowWdata(rowWdata), .rowRdata(rowRdata), .rowRvalid(rowRvalid)
  );
endmodule

// File: tb/tb_cim_array_top.sv
module tb_cim_array_top;
  localparam int ROWS = 8;
  localparam int COLS = 32;
  localparam int NPROG = 23;
  localparam logic [31:0] PROG [NPROG] = '{
    32'h0C00_0000, 32'h0300_0114, 32'h0302_0315, 32'h0700_0016,
    32'h0B00_0000, 32'h0304_0504, 32'h0700_0017, 32'h0806_0000,
    32'h1407_0018, 32'h1508_0008, 32'h0A09_0100, 32'h0900_0019,
    32'h020A_0B0A, 32'h0D0C_0D1A, 32'h000E_0F1B, 32'h0110_111C,
    32'h0612_0000, 32'h0700_001D, 32'h0A13_0000, 32'hE4E0_00FE,
    32'h0E00_0000, 32'h0F00_0000, 32'h0900_001F
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowReq = 1'b0, rowWe = 1'b0;
  logic [2:0] rowAddr = '0;
  logic [COLS-1:0] rowWdata = '0;
  logic rowReady, rowRvalid, instBusy;
  logic [COLS-1:0] rowRdata;
  logic instValid = 1'b0;
  logic [31:0] instWord = '0;

  int checks = 0, fails = 0;
  logic [COLS-1:0] mdl [ROWS];
  logic mc [ROWS];
  logic mt [ROWS];
  string ptag [NPROG];

  always #2 clk = ~clk;

  cim_array_top #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rstN(rstN), .rowReq(rowReq), .rowWe(rowWe), .rowAddr(rowAddr),
    .rowWdata(rowWdata), .rowReady(rowReady), .rowRdata(rowRdata),
    .rowRvalid(rowRvalid), .instValid(instValid), .instWord(instWord),
    .instBusy(instBusy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mApply(input logic [31:0] w);
    logic [3:0] op; logic [4:0] a, b, d; logic cond, pat, ab, bb, res, we;
    op = w[27:24]; a = w[20:16]; b = w[12:8]; d = w[4:0]; cond = w[28]; pat = w[8];
    for (int r = 0; r < ROWS; r++) begin
      ab = mdl[r][a]; bb = mdl[r][b]; res = 1'b0; we = 1'b1;
      case (op)
        4'd0: res = ab & bb;  4'd1: res = ab | bb;  4'd2: res = ab ^ bb;
        4'd13: res = ~(ab | bb); 4'd3: res = ab ^ bb ^ mc[r];
        4'd4: res = ab;  4'd5: res = ~ab;  4'd7: res = mc[r];  4'd9: res = mt[r];
        default: we = 1'b0;
      endcase
      if (cond && !mt[r]) we = 1'b0;
      if (we) mdl[r][d] = res;
      case (op)
        4'd3: mc[r] = (ab & bb) | (ab & mc[r]) | (bb & mc[r]);
        4'd6: mc[r] = ab;  4'd11: mc[r] = 1'b1;  4'd12: mc[r] = 1'b0;
        4'd8: mt[r] = ab;  4'd10: mt[r] = (ab == pat);  4'd14: mt[r] = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic exec(input logic [31:0] w);
    @(negedge clk); instValid = 1'b1; instWord = w;
    @(negedge clk); instValid = 1'b0;
    mApply(w);
  endtask

  task automatic wrRow(input int r, input logic [COLS-1:0] v);
    @(negedge clk); rowReq = 1'b1; rowWe = 1'b1; rowAddr = 3'(r); rowWdata = v;
    @(negedge clk); rowReq = 1'b0; rowWe = 1'b0;
    mdl[r] = v;
  endtask

  task automatic rdRow(input int r, output logic [COLS-1:0] v);
    @(negedge clk); rowReq = 1'b1; rowWe = 1'b0; rowAddr = 3'(r);
    @(negedge clk); rowReq = 1'b0;
    v = rowRdata;
    chk(rowRvalid === 1'b1, "R8 rvalid", 32'(rowRvalid), 32'd1);
  endtask

  task automatic cmpAll(input string req);
    logic [COLS-1:0] v;
    for (int r = 0; r < ROWS; r++) begin
      rdRow(r, v);
      chk(v === mdl[r], req, v, mdl[r]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [COLS-1:0] v;
    ptag = '{"R4 clear carry", "R3 add lsb", "R3 add chained", "R4 store carry",
             "R4 set carry", "R7 add in place", "R3 carry from add", "R5 load tag",
             "R6 conditional copy", "R6 R7 conditional invert in place", "R5 equal pattern 1",
             "R5 store tag", "R2 R7 xor in place", "R2 nor", "R2 and", "R2 or",
             "R4 load carry", "R4 store loaded carry", "R5 equal pattern 0",
             "R1 reserved flags and high column bits", "R5 set tag", "R11 nop",
             "R5 store tag after set"};
    for (int r = 0; r < ROWS; r++) begin mdl[r] = '0; mc[r] = 1'b0; mt[r] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rowRvalid === 1'b0, "R11 rvalid after reset", 32'(rowRvalid), 32'd0);
    chk(rowReady === 1'b1, "R11 rowReady idle", 32'(rowReady), 32'd1);
    chk(instBusy === 1'b0, "R11 instBusy idle", 32'(instBusy), 32'd0);
    rdRow(3, v);
    chk(v === '0, "R11 array cleared", v, 32'd0);
    exec(32'h0900_0000);
    cmpAll("R11 tag cleared by reset");

    for (int r = 0; r < ROWS; r++) wrRow(r, 32'h9E37_79B9 * (r + 1) ^ (32'h5A5A_0F0F >> r));
    cmpAll("R8 row write and read");

    for (int i = 0; i < NPROG; i++) begin
      exec(PROG[i]);
      cmpAll(ptag[i]);
    end

    exec(32'h0B00_0000);
    wrRow(2, 32'h0123_4567);
    exec(32'h0700_0003);
    cmpAll("R8 row write leaves carry");

    @(negedge clk);
    instValid = 1'b1; instWord = 32'h0400_0001;
    rowReq = 1'b1; rowWe = 1'b1; rowAddr = 3'd5; rowWdata = 32'hFFFF_FFFF;
    #1;
    chk(rowReady === 1'b0, "R9 row stalled by instruction", 32'(rowReady), 32'd0);
    chk(instBusy === 1'b0, "R9 instruction accepted", 32'(instBusy), 32'd0);
    @(negedge clk);
    instWord = 32'h0502_0002;
    #1;
    chk(instBusy === 1'b1, "R10 busy after stall", 32'(instBusy), 32'd1);
    chk(rowReady === 1'b1, "R10 row granted", 32'(rowReady), 32'd1);
    @(negedge clk);
    rowReq = 1'b0; rowWe = 1'b0;
    #1;
    chk(instBusy === 1'b0, "R10 busy released", 32'(instBusy), 32'd0);
    @(negedge clk);
    instValid = 1'b0;
    mApply(32'h0400_0001);
    mdl[5] = 32'hFFFF_FFFF;
    mApply(32'h0502_0002);
    cmpAll("R10 ordering copy then write then invert");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule